// File: doc/BRIEF.md
# Overload Fault Timer with Winding-Short Stop

This block decides when a switching power controller must stop driving its power switch because of a sustained overload or a shorted winding. A per-cycle flag from the peak-current limit comparator is integrated by an up/down counter that steps once per fixed tick (10 ms in the target system). If the flag was seen at any time during a tick, the count rises; otherwise it falls. The count saturates at zero, so brief overloads separated by quiet periods are forgiven gradually rather than forgotten at once. When the count reaches its completion value, switching stops.

A second, faster path handles a winding short. A flag from a higher-threshold current comparator is honoured only while the main leading-edge blanking window is open, and stops the drive in the same clock cycle. Both stop paths share one response, picked by a mode input: a latched stop that raises a supply-clamp request and holds until power-on reset, or an auto-recovery stop that waits until the supply has fallen to its turn-off level, issues a one-cycle restart request and resumes with a cleared counter and a fresh tick phase.

Top module: `ovl_fault_timer`

## Requirements
- R1: After reset, `drv_en_o` is 1, `clamp_req_o` is 0 and `restart_o` is 0.
- R2: While running, the counter steps once every `TICK_CYCLES` clock cycles, the first step at the end of the `TICK_CYCLES`-th cycle after reset or restart; it steps up if `peak_lim_i` was 1 in any cycle of that tick window, and down otherwise.
- R3: A down step at a count of 0 leaves the count at 0.
- R4: Completion occurs at the tick whose up step brings the count to `TRIP_TICKS` (default 8); `drv_en_o` is 0 in that same cycle and stays 0 while stopped.
- R5: In latched mode (`latch_sel_i` = 1 at the stop), `clamp_req_o` is 1 from the cycle after the stop and the block stays stopped with the clamp raised until reset; `supply_low_i` has no effect and `restart_o` stays 0.
- R6: In auto-recovery mode (`latch_sel_i` = 0 at the stop), `clamp_req_o` stays 0 and drive stays off until `supply_low_i` is 1; `restart_o` is then 1 for exactly the next cycle, after which `drv_en_o` returns to 1 with the count at 0 and the tick phase restarted.
- R7: `wshort_i` = 1 together with `leb_win_i` = 1 while running drives `drv_en_o` to 0 in the same cycle and takes the same latched or auto-recovery path as R5/R6.
- R8: `wshort_i` = 1 while `leb_win_i` = 0 has no effect on `drv_en_o` or `clamp_req_o`.
- R9: `supply_low_i` while running has no effect: `drv_en_o` stays 1 and `restart_o` stays 0.
- R10: The response mode is taken from `latch_sel_i` in the cycle of the stop; a change of `latch_sel_i` while already stopped does not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only exit from a latched stop |
| peak_lim_i | input | 1 | Peak-current limit reached in the current switching cycle |
| wshort_i | input | 1 | Winding-short comparator output (already blanked by its own short window) |
| leb_win_i | input | 1 | 1 while the main leading-edge blanking interval is open |
| latch_sel_i | input | 1 | Response mode: 1 latched, 0 auto-recovery |
| supply_low_i | input | 1 | Supply has fallen to its turn-off level |
| drv_en_o | output | 1 | Permission for the gate driver to issue pulses |
| clamp_req_o | output | 1 | Request to clamp the supply in the latched stop |
| restart_o | output | 1 | One-cycle request for a fresh startup sequence |

## Verification
The bench drives the counter through up, down and up again sequences so that a counter that resets instead of counting down, that wraps below zero, or that trips one tick early or late leaves the drive in the wrong state. It pulses the peak flag for a single cycle per tick window to catch a design that only samples the flag at the tick edge, and checks the drive in the exact cycle before and at completion to catch an extra register stage. The short path is hit both inside and outside the blanking window, so an ungated or a delayed short stop shows up, and the auto-recovery case checks that the restart clears the count and that a mode change while stopped is not taken late.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_LATCH   = 2'd1,
      ST_HOLD    = 2'd2,
      ST_RESTART = 2'd3
   } stop_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_value);
      return (max_value < 2) ? 1 : $clog2(max_value + 1);
   endfunction

endpackage

// File: rtl/ovl_tick_gen.sv
module ovl_tick_gen #(
   parameter int unsigned TICK_CYCLES = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   generate
      if (TICK_CYCLES < 1) begin : g_bad
         $error("ovl_tick_gen: TICK_CYCLES must be at least 1");
      end

      if (TICK_CYCLES == 1) begin : g_every
         assign tick_o = run_i;
      end else begin : g_div
         localparam int unsigned PW = ovl_pkg::cnt_width(TICK_CYCLES - 1);
         localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run_i) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick_o = run_i && (phase_q == LAST);

         // R2: ticks are isolated pulses, never back to back
         a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/ovl_updown.sv
module ovl_updown #(
   parameter int unsigned TRIP_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   input  logic peak_i,
   output logic [ovl_pkg::cnt_width(TRIP_TICKS)-1:0] count_o,
   output logic done_o
);
   localparam int unsigned CW = ovl_pkg::cnt_width(TRIP_TICKS);
   localparam logic [CW-1:0] TOP  = CW'(TRIP_TICKS);
   localparam logic [CW-1:0] NEAR = CW'(TRIP_TICKS - 1);

   generate
      if (TRIP_TICKS < 1) begin : g_bad
         $error("ovl_updown: TRIP_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] count_q;
   logic          seen_q;
   logic          hit;

   assign hit = seen_q | peak_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
      end else if (clr_i || tick_i) begin
         seen_q <= 1'b0;
      end else if (peak_i) begin
         seen_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clr_i) begin
         count_q <= '0;
      end else if (tick_i) begin
         if (hit) begin
            if (count_q != TOP) count_q <= count_q + 1'b1;
         end else begin
            if (count_q != '0) count_q <= count_q - 1'b1;
         end
      end
   end

   assign count_o = count_q;
   assign done_o  = tick_i && hit && (count_q == NEAR);

   // R2: the count only moves on a tick or a clear
   a_r2_no_step_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(count_q));
   // R3: floor at zero
   a_r3_floor_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !hit && !clr_i && count_q == '0) |=> (count_q == '0));
   // R4: never beyond the completion value
   a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= TOP);
endmodule

// File: rtl/ovl_stop_ctrl.sv
module ovl_stop_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_i,
   input  logic wshort_i,
   input  logic leb_win_i,
   input  logic latch_sel_i,
   input  logic supply_low_i,
   output logic run_o,
   output logic clr_o,
   output logic drv_en_o,
   output logic clamp_o,
   output logic restart_o
);
   import ovl_pkg::*;

   stop_state_t state_q, state_d;
   logic short_hit;
   logic stop_now;

   assign short_hit = wshort_i && leb_win_i;
   assign run_o     = (state_q == ST_RUN);
   assign stop_now  = run_o && (trip_i || short_hit);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (stop_now) state_d = latch_sel_i ? ST_LATCH : ST_HOLD;
         ST_HOLD:    if (supply_low_i) state_d = ST_RESTART;
         ST_RESTART: state_d = ST_RUN;
         ST_LATCH:   state_d = ST_LATCH;
         default:    state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign drv_en_o  = run_o && !stop_now;
   assign clamp_o   = (state_q == ST_LATCH);
   assign restart_o = (state_q == ST_RESTART);
   assign clr_o     = restart_o;

   // R5: a latched stop never leaves
   a_r5_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCH) |=> (state_q == ST_LATCH));
   // R6: restart is a single-cycle pulse followed by running
   a_r6_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |=> (!restart_o && run_o));
   // R6: auto-recovery hold waits for the supply flag
   a_r6_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && !supply_low_i) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/ovl_fault_timer.sv
module ovl_fault_timer #(
   parameter int unsigned TICK_CYCLES = 1000000,
   parameter int unsigned TRIP_TICKS  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic peak_lim_i,
   input  logic wshort_i,
   input  logic leb_win_i,
   input  logic latch_sel_i,
   input  logic supply_low_i,
   output logic drv_en_o,
   output logic clamp_req_o,
   output logic restart_o
);
   localparam int unsigned CW = ovl_pkg::cnt_width(TRIP_TICKS);

   logic          run;
   logic          clr;
   logic          tick;
   logic          done;
   logic [CW-1:0] count;

   ovl_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   ovl_updown #(.TRIP_TICKS(TRIP_TICKS)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .tick_i  (tick),
      .peak_i  (peak_lim_i),
      .count_o (count),
      .done_o  (done)
   );

   ovl_stop_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .trip_i       (done),
      .wshort_i     (wshort_i),
      .leb_win_i    (leb_win_i),
      .latch_sel_i  (latch_sel_i),
      .supply_low_i (supply_low_i),
      .run_o        (run),
      .clr_o        (clr),
      .drv_en_o     (drv_en_o),
      .clamp_o      (clamp_req_o),
      .restart_o    (restart_o)
   );

   // R6: the restart leaves the counter empty
   a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |=> (count == '0));
   // R5: drive is never enabled while the clamp is requested
   a_r5_clamp_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_req_o |-> !drv_en_o);
   // R7: a qualified winding short keeps drive off on the following cycle
   a_r7_short_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (wshort_i && leb_win_i) |=> !drv_en_o);
endmodule

// File: tb/tb_ovl_fault_timer.sv
module tb_ovl_fault_timer;
   localparam int TICK = 8;
   localparam int TRIP = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic peak_lim_i, wshort_i, leb_win_i, latch_sel_i, supply_low_i;
   logic drv_en_o, clamp_req_o, restart_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ovl_fault_timer #(.TICK_CYCLES(TICK), .TRIP_TICKS(TRIP)) dut (
      .clk(clk), .rst_n(rst_n), .peak_lim_i(peak_lim_i), .wshort_i(wshort_i),
      .leb_win_i(leb_win_i), .latch_sel_i(latch_sel_i), .supply_low_i(supply_low_i),
      .drv_en_o(drv_en_o), .clamp_req_o(clamp_req_o), .restart_o(restart_o)
   );

   // up ticks, down ticks, up ticks, expected trip
   localparam int VEC [6][4] = '{
      '{8, 0, 0, 1},
      '{7, 0, 0, 0},
      '{5, 3, 6, 1},
      '{5, 3, 5, 0},
      '{3, 6, 8, 1},
      '{3, 6, 7, 0}
   };

   task automatic check(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic latched);
      rst_n = 1'b0;
      peak_lim_i = 0; wshort_i = 0; leb_win_i = 0; supply_low_i = 0;
      latch_sel_i = latched;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic windows(input int n, input logic val);
      peak_lim_i = val;
      repeat (n * TICK) @(negedge clk);
   endtask

   task automatic pulse_windows(input int n);
      for (int w = 0; w < n; w++) begin
         for (int c = 0; c < TICK; c++) begin
            peak_lim_i = (c == 3);
            @(negedge clk);
         end
      end
      peak_lim_i = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic bad;
      @(negedge clk);
      // R1 reset state
      do_reset(1'b1);
      #1;
      check(drv_en_o, 1'b1, "R1 drv_en after reset");
      check(clamp_req_o, 1'b0, "R1 clamp after reset");
      check(restart_o, 1'b0, "R1 restart after reset");

      // R2 R3 R4 R5: vector table in latched mode
      for (int v = 0; v < 6; v++) begin
         do_reset(1'b1);
         windows(VEC[v][0], 1'b1);
         windows(VEC[v][1], 1'b0);
         windows(VEC[v][2], 1'b1);
         peak_lim_i = 0;
         #1;
         check(drv_en_o, !VEC[v][3][0], $sformatf("R2 R3 R4 vector %0d drv_en", v));
         check(clamp_req_o, VEC[v][3][0], $sformatf("R5 vector %0d clamp", v));
      end

      // R4 exact completion cycle
      do_reset(1'b1);
      peak_lim_i = 1;
      repeat (TICK * TRIP - 2) @(negedge clk);
      #1 check(drv_en_o, 1'b1, "R4 drv_en one cycle before completion");
      @(negedge clk); #1;
      check(drv_en_o, 1'b0, "R4 drv_en in completion cycle");
      check(clamp_req_o, 1'b0, "R5 clamp not yet in completion cycle");
      @(negedge clk); #1;
      check(clamp_req_o, 1'b1, "R5 clamp after completion");
      // R5 supply_low ignored in latched stop
      peak_lim_i = 0; supply_low_i = 1; bad = 0;
      repeat (20) begin
         @(negedge clk); #1;
         if (drv_en_o || !clamp_req_o || restart_o) bad = 1;
      end
      check(bad, 1'b0, "R5 latched stop held with supply_low");
      supply_low_i = 0;

      // R2 flag seen at any time in the window
      do_reset(1'b1);
      pulse_windows(TRIP - 1);
      #1 check(drv_en_o, 1'b1, "R2 single-cycle peak pulses, one short");
      pulse_windows(1);
      #1 check(drv_en_o, 1'b0, "R2 single-cycle peak pulses trip");

      // R6 R10 auto recovery
      do_reset(1'b0);
      windows(TRIP, 1'b1);
      peak_lim_i = 0;
      #1;
      check(drv_en_o, 1'b0, "R6 auto stop drv_en");
      check(clamp_req_o, 1'b0, "R6 auto stop no clamp");
      latch_sel_i = 1; bad = 0;
      repeat (30) begin
         @(negedge clk); #1;
         if (drv_en_o || clamp_req_o || restart_o) bad = 1;
      end
      check(bad, 1'b0, "R6 R10 auto stop waits, mode change ignored");
      supply_low_i = 1;
      @(negedge clk); #1;
      check(restart_o, 1'b1, "R6 restart pulse");
      supply_low_i = 0;
      @(negedge clk); #1;
      check(restart_o, 1'b0, "R6 restart one cycle");
      check(drv_en_o, 1'b1, "R6 drive resumes");
      windows(TRIP - 1, 1'b1);
      #1 check(drv_en_o, 1'b1, "R6 counter cleared by restart");
      windows(1, 1'b1);
      peak_lim_i = 0;
      #1;
      check(drv_en_o, 1'b0, "R6 trip after restart");
      check(clamp_req_o, 1'b1, "R10 mode taken at second stop");

      // R8 short outside blanking window ignored
      do_reset(1'b1);
      wshort_i = 1; leb_win_i = 0; bad = 0;
      repeat (20) begin
         @(negedge clk); #1;
         if (!drv_en_o || clamp_req_o) bad = 1;
      end
      check(bad, 1'b0, "R8 short ignored outside window");
      // R7 short inside window, latched
      leb_win_i = 1; #1;
      check(drv_en_o, 1'b0, "R7 short stops same cycle");
      @(negedge clk); wshort_i = 0; leb_win_i = 0; #1;
      check(clamp_req_o, 1'b1, "R7 short latched clamp");

      // R7 short, auto recovery
      do_reset(1'b0);
      wshort_i = 1; leb_win_i = 1; #1;
      check(drv_en_o, 1'b0, "R7 auto short stops same cycle");
      @(negedge clk); wshort_i = 0; leb_win_i = 0; #1;
      check(clamp_req_o, 1'b0, "R7 auto short no clamp");
      check(drv_en_o, 1'b0, "R7 auto short drive off");
      supply_low_i = 1;
      @(negedge clk); #1;
      check(restart_o, 1'b1, "R7 auto short restart");
      supply_low_i = 0;

      // R9 supply_low while running ignored
      do_reset(1'b1);
      supply_low_i = 1; bad = 0;
      repeat (20) begin
         @(negedge clk); #1;
         if (!drv_en_o || restart_o) bad = 1;
      end
      check(bad, 1'b0, "R9 supply_low ignored while running");
      supply_low_i = 0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule